// File: doc/BRIEF.md
# Half-Bridge Cross-Conduction Lock with Dead-Time Timer

This block converts the switching requests for one half-bridge leg into two registered gate-enable outputs, one for the lower switch and one for the upper switch. The upper switch is requested by an active-high input. The lower switch is requested by an active-low input. A synchronous active-low force-off input overrides both requests. The block never lets both switches conduct at once. Before either gate turns on, it keeps a guard interval in which both gates are low. The length of that interval comes from a clock-cycle count on an input bus.

All requests are sampled on the rising clock edge. The outputs change at that same edge, so an output reflects the inputs from the cycle before it. The two request inputs may be tied to one control line. With value 1 that line requests the upper switch, and with value 0 it requests the lower switch, which gives complementary switching with a guard gap. The decoded request takes one of three values: off, lower or upper.

Top module: `hb_deadtime_gen`

## Requirements
- R1: While `sd_n` is 0 at a clock edge, `lvg` and `hvg` are both 0 after that edge, whatever `hin`, `lin_n` and `dt_cycles` are.
- R2: With `sd_n`=1, `hin`=0 and `lin_n`=0 (lower request), only `lvg` can be 1, and only once the guard interval is complete.
- R3: With `sd_n`=1, `hin`=1 and `lin_n`=1 (upper request), only `hvg` can be 1, and only once the guard interval is complete.
- R4: With `sd_n`=1, `hin`=1 and `lin_n`=0 (both sides requested), both outputs are 0 after the edge.
- R5: With `sd_n`=1, `hin`=0 and `lin_n`=1 (no request), both outputs are 0 after the edge.
- R6: An output turns off at the first edge where its request is no longer valid. A gate may turn on only at an edge where the count of consecutive cycles with both gates low has reached `dt_cycles`. That count is 1 in the first such cycle.
- R7: If a request arrives after the guard interval has already completed, the requested gate turns on at the very next edge.
- R8: With `hin` and `lin_n` driven by one shared line, the outputs alternate, and exactly max(`dt_cycles`,1) low cycles separate the two gates.
- R9: If the decoded request changes while the guard count is still running, the count restarts from 1 in the cycle of the change.
- R10: With `dt_cycles`=0, a switch-over still has exactly one cycle with both gates low.
- R11: Reset drives both outputs to 0 and loads the guard count with 1. A request held from reset release turns its gate on after exactly `dt_cycles` low samples when `dt_cycles` is 2 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hin | input | 1 | Upper-switch request, active high |
| lin_n | input | 1 | Lower-switch request, active low |
| sd_n | input | 1 | Synchronous force-off, active low |
| dt_cycles | input | DT_W | Guard interval in clock cycles |
| lvg | output | 1 | Lower gate enable |
| hvg | output | 1 | Upper gate enable |

## Verification
A turn-off and the restart of the guard count can fall on the same edge. A turn-on and a request change can also fall on the same edge, and the direct-follow case and the restart case compete for that edge. The bench provokes these collisions by sweeping every ordered pair of input codes, including the force-off input, with hold times of one to three cycles against several guard lengths. Each cycle it compares both outputs with a cycle-level model written from the requirements. Directed runs then measure the exact number of low cycles in three cases: a switch-over from a shared control line, a request that changes while the count is running, and the first turn-on after reset.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;

  typedef enum logic [1:0] {
    SIDE_OFF = 2'b00,
    SIDE_LO  = 2'b01,
    SIDE_HI  = 2'b10
  } side_e;

  // Map the raw inputs onto the side that is being requested.
  function automatic side_e decode_side(input logic hin, input logic lin_n,
                                        input logic sd_n);
    side_e s;
    if (!sd_n)              s = SIDE_OFF;
    else if (hin && lin_n)  s = SIDE_HI;
    else if (!hin && !lin_n) s = SIDE_LO;
    else                    s = SIDE_OFF;
    return s;
  endfunction

endpackage

// File: rtl/hb_req_decode.sv
module hb_req_decode
  import hb_dt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hin,
  input  logic  lin_n,
  input  logic  sd_n,
  output side_e tgt,
  output logic  tgt_chg
);

  side_e tgt_q;
  side_e tgt_d;

  always_comb begin
    tgt     = decode_side(hin, lin_n, sd_n);
    tgt_chg = (tgt != tgt_q);
    tgt_d   = tgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgt_q <= SIDE_OFF;
    else        tgt_q <= tgt_d;
  end

endmodule

// File: rtl/hb_gap_timer.sv
module hb_gap_timer #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [DT_W-1:0] dt,
  output logic            done
);

  localparam logic [DT_W-1:0] CNT_ONE = DT_W'(1);

  logic [DT_W-1:0] cnt_q;
  logic [DT_W-1:0] cnt_d;
  logic            cnt_en;

  always_comb begin
    done   = (cnt_q >= dt);
    cnt_en = load || !done;
    cnt_d  = load ? CNT_ONE : (cnt_q + CNT_ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_ONE;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R9: a load always restarts the guard count at one
  p_load_restart_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == CNT_ONE));

endmodule

// File: rtl/hb_gate_fsm.sv
module hb_gate_fsm
  import hb_dt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  side_e tgt,
  input  logic  tgt_chg,
  input  logic  done,
  output side_e cur,
  output logic  load
);

  side_e cur_q;
  side_e cur_d;
  logic  turn_on;

  always_comb begin
    cur_d   = cur_q;
    turn_on = 1'b0;
    if (cur_q != SIDE_OFF) begin
      if (tgt != cur_q) cur_d = SIDE_OFF;
    end else if ((tgt != SIDE_OFF) && done) begin
      cur_d   = tgt;
      turn_on = 1'b1;
    end
    load = (cur_q != SIDE_OFF) || turn_on || (tgt_chg && !done);
    cur  = cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= SIDE_OFF;
    else        cur_q <= cur_d;
  end

endmodule

// File: rtl/hb_deadtime_gen.sv
module hb_deadtime_gen
  import hb_dt_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hin,
  input  logic            lin_n,
  input  logic            sd_n,
  input  logic [DT_W-1:0] dt_cycles,
  output logic            lvg,
  output logic            hvg
);

  localparam int RUN_W = DT_W + 1;

  side_e tgt;
  side_e cur;
  logic  tgt_chg;
  logic  load;
  logic  done;

  hb_req_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .hin     (hin),
    .lin_n   (lin_n),
    .sd_n    (sd_n),
    .tgt     (tgt),
    .tgt_chg (tgt_chg)
  );

  hb_gap_timer #(.DT_W(DT_W)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .dt    (dt_cycles),
    .done  (done)
  );

  hb_gate_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .tgt     (tgt),
    .tgt_chg (tgt_chg),
    .done    (done),
    .cur     (cur),
    .load    (load)
  );

  assign lvg = (cur == SIDE_LO);
  assign hvg = (cur == SIDE_HI);

  // Run length of cycles with both gates low, used only by the gap check.
  logic [RUN_W-1:0] low_run_q;
  logic [RUN_W-1:0] low_run_d;

  always_comb begin
    if (lvg || hvg)         low_run_d = '0;
    else if (&low_run_q)    low_run_d = low_run_q;
    else                    low_run_d = low_run_q + RUN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run_q <= '0;
    else        low_run_q <= low_run_d;
  end

  // R1: force-off clears both gates at the next edge
  p_force_off_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    !sd_n |=> (!lvg && !hvg));

  // R2: the lower gate is on only for a lower-only request
  p_lo_only_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    lvg |-> $past(sd_n && !lin_n && !hin));

  // R3: the upper gate is on only for an upper-only request
  p_hi_only_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    hvg |-> $past(sd_n && lin_n && hin));

  // R4: a request for both sides locks both gates off
  p_interlock_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (sd_n && hin && !lin_n) |=> (!lvg && !hvg));

  // R5: no request leaves both gates off
  p_idle_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (sd_n && !hin && lin_n) |=> (!lvg && !hvg));

  // R6, R10: every turn-on follows at least max(dt,1) low cycles
  p_dead_gap_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvg || hvg) |->
      ((low_run_q >= {1'b0, $past(dt_cycles)}) && (low_run_q != '0)));

endmodule

// File: tb/hb_deadtime_gen_tb.sv
module hb_deadtime_gen_tb;

  localparam int DT_W = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            hin = 1'b0;
  logic            lin_n = 1'b1;
  logic            sd_n = 1'b1;
  logic [DT_W-1:0] dt_cycles = '0;
  logic            lvg;
  logic            hvg;

  int n_chk = 0;
  int n_bad = 0;
  bit model_on = 1'b1;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hb_deadtime_gen #(.DT_W(DT_W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .hin       (hin),
    .lin_n     (lin_n),
    .sd_n      (sd_n),
    .dt_cycles (dt_cycles),
    .lvg       (lvg),
    .hvg       (hvg)
  );

  // Cycle-level model from the requirements: 0 none, 1 lower, 2 upper.
  int m_on;
  int m_low;
  int m_prev;
  logic [2:0] last_in;

  function automatic int want(input logic s, input logic h, input logic l);
    if (!s) return 0;
    if (h && l) return 2;
    if (!h && !l) return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_on <= 0; m_low <= 1; m_prev <= 0; last_in <= 3'b101;
    end else begin
      int t;
      t = want(sd_n, hin, lin_n);
      last_in <= {sd_n, hin, lin_n};
      if (m_on != 0) begin
        if (t != m_on) m_on <= 0;
        m_low <= 1;
      end else if (t != 0 && m_low >= int'(dt_cycles)) begin
        m_on <= t; m_low <= 1;
      end else if (t != m_prev && m_low < int'(dt_cycles)) begin
        m_low <= 1;
      end else if (m_low < int'(dt_cycles)) begin
        m_low <= m_low + 1;
      end
      m_prev <= t;
    end
  end

  function automatic string tag_of(input logic [2:0] c);
    if (!c[2]) return "R1";
    if (c[1] && !c[0]) return "R4";
    if (!c[1] && c[0]) return "R5";
    if (!c[1]) return "R2,R6,R9";
    return "R3,R6,R9";
  endfunction

  task automatic chk(input string tag, input logic al, input logic ah,
                     input logic el, input logic eh);
    n_chk++;
    if (al !== el || ah !== eh) begin
      n_bad++;
      $display("FAIL %s: lvg/hvg actual %b%b expected %b%b at %0t",
               tag, al, ah, el, eh, $time);
    end
  endtask

  task automatic step_cmp();
    @(negedge clk);
    if (model_on) chk(tag_of(last_in), lvg, hvg, m_on == 1, m_on == 2);
  endtask

  task automatic put(input logic [2:0] c);
    sd_n = c[2]; hin = c[1]; lin_n = c[0];
  endtask

  // Count low samples until gate g (1 lower, 2 upper) rises; the other must stay low.
  task automatic low_until(input int g, output int n);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if ((g == 1 && hvg) || (g == 2 && lvg)) begin
        n_chk++; n_bad++;
        $display("FAIL R8: wrong gate high actual %b%b expected gate %0d", lvg, hvg, g);
      end
      if ((g == 1 && lvg) || (g == 2 && hvg)) break;
      n++;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    int exp_n;
    logic [15:0] lfsr;
    // R11: outputs low during reset even with a request present
    put(3'b100);
    dt_cycles = 4'd3;
    repeat (3) @(negedge clk);
    chk("R11", lvg, hvg, 1'b0, 1'b0);
    rst_n = 1'b1;
    // R11: request held from release turns on after exactly dt low samples
    model_on = 1'b0;
    low_until(1, n);
    n_chk++;
    if (n != 3) begin
      n_bad++;
      $display("FAIL R11: low samples actual %0d expected %0d", n, 3);
    end
    model_on = 1'b1;

    // Pairwise sweep of every input code against several guard lengths
    for (int d = 0; d < 6; d++) begin
      dt_cycles = DT_W'(d);
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          for (int hb = 1; hb < 4; hb++) begin
            put(3'(a));
            repeat (8) step_cmp();
            put(3'(b));
            repeat (hb) step_cmp();
          end
    end

    // Pseudo-random run with the guard length changed every segment
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 200 == 0) dt_cycles = DT_W'(lfsr[3:0] % 7);
      if (lfsr[4] || lfsr[5]) put({1'b1, lfsr[7:6]});
      if (lfsr[8:6] == 3'b000) put({1'b0, lfsr[10:9]});
      step_cmp();
    end

    // R7: request arriving after a completed guard interval follows at once
    model_on = 1'b0;
    dt_cycles = 4'd3;
    put(3'b100); repeat (12) @(negedge clk);
    put(3'b101); repeat (8) @(negedge clk);
    put(3'b111); @(negedge clk);
    chk("R7", lvg, hvg, 1'b0, 1'b1);

    // R9: a request change during the count restarts it
    dt_cycles = 4'd4;
    put(3'b100); repeat (12) @(negedge clk);
    put(3'b101); repeat (2) @(negedge clk);
    chk("R9", lvg, hvg, 1'b0, 1'b0);
    put(3'b111);
    low_until(2, n);
    n_chk++;
    if (n != 4) begin
      n_bad++;
      $display("FAIL R9: low samples after change actual %0d expected %0d", n, 4);
    end

    // R8, R10: hin and lin_n from one shared line
    for (int k = 0; k < 4; k++) begin
      int d;
      d = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 2 : 5;
      dt_cycles = DT_W'(d);
      exp_n = (d == 0) ? 1 : d;
      sd_n = 1'b1; hin = 1'b0; lin_n = 1'b0;
      repeat (12) @(negedge clk);
      hin = 1'b1; lin_n = 1'b1;
      low_until(2, n);
      n_chk++;
      if (n != exp_n) begin
        n_bad++;
        $display("FAIL R8,R10: gap to upper actual %0d expected %0d", n, exp_n);
      end
      repeat (3) @(negedge clk);
      hin = 1'b0; lin_n = 1'b0;
      low_until(1, n);
      n_chk++;
      if (n != exp_n) begin
        n_bad++;
        $display("FAIL R8,R10: gap to lower actual %0d expected %0d", n, exp_n);
      end
    end

    // R1: force-off while a gate is on
    put(3'b000); @(negedge clk);
    chk("R1", lvg, hvg, 1'b0, 1'b0);

    // R11: reset in mid-operation clears the outputs
    put(3'b100); repeat (10) @(negedge clk);
    rst_n = 1'b0; @(negedge clk);
    chk("R11", lvg, hvg, 1'b0, 1'b0);
    finish_run();
  end

endmodule